// File: doc/BRIEF.md
# Dual-Issue Pairing Logic

This block sits between the instruction buffer and two integer execution pipes. Each cycle it looks at the two oldest decoded instructions and decides whether the older one issues to the primary pipe and whether the younger one may go with it to the secondary pipe. The decision is registered, so the issue strobes, the secondary's operand-forwarding selects and the count of instructions taken from the buffer all appear one clock after the descriptors are presented.

Pairing is refused when the younger instruction belongs to a class the secondary pipe cannot run, when either instruction must run alone, or when the younger one reads a register the older one writes. That last rule has an exception. When the older instruction produces a full 32-bit result early (a plain long register move, address computation, long immediate load, quick load, or long clear of a data register), the result is bypassed into the secondary and the pair still issues. A secondary slot holds a bounded amount of extension data, so an instruction that needs more than that stays on the primary pipe.

Top module: `dual_issue_pair`

## Requirements
- R1: Issue is in order. `secIssue` is never high unless `priIssue` is high in the same cycle. `consumed` equals the number of issued instructions (0, 1 or 2). All outputs change on the clock edge that follows the cycle in which the descriptors are presented.
- R2: If `stall` is high, or slot 0 is invalid, neither pipe issues. If slot 1 is invalid, no secondary issue occurs.
- R3: Class code 7 (solo) must run alone. As slot 0 it issues with no partner. As slot 1 it never goes to the secondary pipe.
- R4: Class code 6 is a conditional branch predicted not-taken. In slot 0 it pairs with an independent non-branch slot-1 instruction. In slot 1 it never issues on the secondary pipe.
- R5: A slot-1 instruction with more than 6 extension bytes is refused for the secondary pipe, while exactly 6 is accepted. The extension byte count of slot 0 does not prevent pairing.
- R6: If slot 0 has its destination enabled and slot 1 reads that register through an enabled source (A or B), the pair is refused unless R7 allows it. A source that is disabled, or a slot-0 destination that is disabled, never creates a dependency.
- R7: A dependent pair is allowed through forwarding when slot 0 has size code 2 (long) and one of the following holds: its class is 1 (long register move), 2 (address computation), 3 (long immediate load) or 4 (quick load); or its class is 5 (long clear) and its destination is a data register (index 0 to 7; indices 8 to 15 are address registers).
- R8: Size codes are 0 = byte, 1 = word, 2 = long. An early-result class with a byte or word size does not forward, so a dependent pair is refused.
- R9: `secFwdA` and `secFwdB` are high only when the pair issues and the matching secondary source is the primary's destination. Otherwise they are low.
- R10: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| stall | input | 1 | Hold both pipes this cycle |
| s0Valid | input | 1 | Slot 0 (older) descriptor valid |
| s0Class | input | 3 | Slot 0 class code |
| s0SrcA | input | 4 | Slot 0 source A register index |
| s0SrcAEn | input | 1 | Slot 0 source A used |
| s0SrcB | input | 4 | Slot 0 source B register index |
| s0SrcBEn | input | 1 | Slot 0 source B used |
| s0Dst | input | 4 | Slot 0 destination register index |
| s0DstEn | input | 1 | Slot 0 writes a register |
| s0Size | input | 2 | Slot 0 result size code |
| s0Ext | input | 5 | Slot 0 extension byte count |
| s1Valid | input | 1 | Slot 1 (younger) descriptor valid |
| s1Class | input | 3 | Slot 1 class code |
| s1SrcA | input | 4 | Slot 1 source A register index |
| s1SrcAEn | input | 1 | Slot 1 source A used |
| s1SrcB | input | 4 | Slot 1 source B register index |
| s1SrcBEn | input | 1 | Slot 1 source B used |
| s1Dst | input | 4 | Slot 1 destination register index |
| s1DstEn | input | 1 | Slot 1 writes a register |
| s1Size | input | 2 | Slot 1 result size code |
| s1Ext | input | 5 | Slot 1 extension byte count |
| priIssue | output | 1 | Slot 0 issues to the primary pipe |
| secIssue | output | 1 | Slot 1 issues to the secondary pipe |
| secFwdA | output | 1 | Secondary source A taken from the primary's early result |
| secFwdB | output | 1 | Secondary source B taken from the primary's early result |
| consumed | output | 2 | Instructions removed from the buffer |

## Verification
A wrong dependency comparator or an incorrect early-result decode shows up at the ports one clock after the pair is presented, in one of two ways. A dependent pair may be wrongly refused, so `secIssue` is low and `consumed` is 1. Or an unsafe pair may be issued with `secFwdA` or `secFwdB` wrong. A bad class or extension-size gate appears in that same cycle as a secondary issue for an instruction that must stay on the primary pipe. The stimulus pairs each dependency case with a near miss: a disabled source, a disabled destination, a byte or word size, an address-register clear, or 6 against 7 extension bytes. This way each gate is seen both open and closed.

// File: rtl/pair_pkg.sv
package pair_pkg;
  parameter int REG_IDX_W    = 4;
  parameter int EXT_CNT_W    = 5;
  parameter int SLOT_EXT_MAX = 6;
  parameter int NUM_SRC      = 2;

  localparam int CNT_W = $clog2(NUM_SRC + 1);

  typedef enum logic [2:0] {
    CLS_ALU  = 3'd0,
    CLS_MOVL = 3'd1,
    CLS_LEA  = 3'd2,
    CLS_MOVI = 3'd3,
    CLS_MOVQ = 3'd4,
    CLS_CLRL = 3'd5,
    CLS_BRNT = 3'd6,
    CLS_SOLO = 3'd7
  } instClass_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } opSize_t;

  // datapath -> control: comparator results
  typedef struct packed {
    logic [NUM_SRC-1:0] srcHit;
    logic               secExtFits;
    logic               priDstIsData;
  } hazInfo_t;

  // control -> datapath: issue strobes
  typedef struct packed {
    logic               issuePri;
    logic               issueSec;
    logic [NUM_SRC-1:0] fwdSel;
  } issueStrobe_t;
endpackage

// File: rtl/pair_datapath.sv
module pair_datapath
  import pair_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [REG_IDX_W-1:0]          priDst,
  input  logic                          priDstEn,
  input  logic [NUM_SRC-1:0][REG_IDX_W-1:0] secSrc,
  input  logic [NUM_SRC-1:0]            secSrcEn,
  input  logic [EXT_CNT_W-1:0]          secExt,
  input  issueStrobe_t                  strobe,
  output hazInfo_t                      haz,
  output logic                          priIssueQ,
  output logic                          secIssueQ,
  output logic [NUM_SRC-1:0]            secFwdQ,
  output logic [1:0]                    consumedQ
);
  logic [NUM_SRC-1:0] srcHit;

  // one comparator per secondary source operand
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign srcHit[g] = secSrcEn[g] && priDstEn && (secSrc[g] == priDst);
  end

  assign haz.srcHit       = srcHit;
  assign haz.secExtFits   = (secExt <= EXT_CNT_W'(SLOT_EXT_MAX));
  assign haz.priDstIsData = ~priDst[REG_IDX_W-1];

  logic [1:0] issueCount;
  assign issueCount = {1'b0, strobe.issuePri} + {1'b0, strobe.issueSec};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priIssueQ <= 1'b0;
      secIssueQ <= 1'b0;
      secFwdQ   <= '0;
      consumedQ <= 2'd0;
    end else begin
      priIssueQ <= strobe.issuePri;
      secIssueQ <= strobe.issueSec;
      secFwdQ   <= strobe.fwdSel;
      consumedQ <= issueCount;
    end
  end
endmodule

// File: rtl/pair_ctrl.sv
module pair_ctrl
  import pair_pkg::*;
(
  input  logic         stall,
  input  logic         priValid,
  input  instClass_t   priCls,
  input  opSize_t      priSize,
  input  logic         secValid,
  input  instClass_t   secCls,
  input  hazInfo_t     haz,
  output issueStrobe_t strobe
);
  logic earlyClass;
  logic earlyOk;
  logic priGo;
  logic secClassOk;
  logic priPairOk;
  logic depBlock;
  logic secGo;

  always_comb begin
    unique case (priCls)
      CLS_MOVL, CLS_LEA, CLS_MOVI, CLS_MOVQ: earlyClass = 1'b1;
      CLS_CLRL:                             earlyClass = haz.priDstIsData;
      default:                              earlyClass = 1'b0;
    endcase
  end

  assign earlyOk    = earlyClass && (priSize == SZ_LONG);
  assign priGo      = priValid && !stall;
  assign secClassOk = (secCls != CLS_SOLO) && (secCls != CLS_BRNT);
  assign priPairOk  = (priCls != CLS_SOLO);
  assign depBlock   = (|haz.srcHit) && !earlyOk;
  assign secGo      = priGo && secValid && secClassOk && priPairOk &&
                      haz.secExtFits && !depBlock;

  assign strobe.issuePri = priGo;
  assign strobe.issueSec = secGo;
  assign strobe.fwdSel   = secGo ? haz.srcHit : '0;
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import pair_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stall,
  input  logic                 s0Valid,
  input  logic [2:0]           s0Class,
  input  logic [REG_IDX_W-1:0] s0SrcA,
  input  logic                 s0SrcAEn,
  input  logic [REG_IDX_W-1:0] s0SrcB,
  input  logic                 s0SrcBEn,
  input  logic [REG_IDX_W-1:0] s0Dst,
  input  logic                 s0DstEn,
  input  logic [1:0]           s0Size,
  input  logic [EXT_CNT_W-1:0] s0Ext,
  input  logic                 s1Valid,
  input  logic [2:0]           s1Class,
  input  logic [REG_IDX_W-1:0] s1SrcA,
  input  logic                 s1SrcAEn,
  input  logic [REG_IDX_W-1:0] s1SrcB,
  input  logic                 s1SrcBEn,
  input  logic [REG_IDX_W-1:0] s1Dst,
  input  logic                 s1DstEn,
  input  logic [1:0]           s1Size,
  input  logic [EXT_CNT_W-1:0] s1Ext,
  output logic                 priIssue,
  output logic                 secIssue,
  output logic                 secFwdA,
  output logic                 secFwdB,
  output logic [1:0]           consumed
);
  hazInfo_t     haz;
  issueStrobe_t strobe;
  logic [NUM_SRC-1:0] secFwdQ;
  logic [NUM_SRC-1:0][REG_IDX_W-1:0] secSrc;
  logic [NUM_SRC-1:0] secSrcEn;

  // fields the pairing decision does not look at
  logic unusedFields;
  assign unusedFields = ^{s0SrcA, s0SrcAEn, s0SrcB, s0SrcBEn, s0Ext,
                          s1Dst, s1DstEn, s1Size};

  assign secSrc   = {s1SrcB, s1SrcA};
  assign secSrcEn = {s1SrcBEn, s1SrcAEn};

  pair_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .priDst    (s0Dst),
    .priDstEn  (s0DstEn),
    .secSrc    (secSrc),
    .secSrcEn  (secSrcEn),
    .secExt    (s1Ext),
    .strobe    (strobe),
    .haz       (haz),
    .priIssueQ (priIssue),
    .secIssueQ (secIssue),
    .secFwdQ   (secFwdQ),
    .consumedQ (consumed)
  );

  pair_ctrl u_ctrl (
    .stall    (stall),
    .priValid (s0Valid),
    .priCls   (instClass_t'(s0Class)),
    .priSize  (opSize_t'(s0Size)),
    .secValid (s1Valid),
    .secCls   (instClass_t'(s1Class)),
    .haz      (haz),
    .strobe   (strobe)
  );

  assign secFwdA = secFwdQ[0];
  assign secFwdB = secFwdQ[1];
endmodule

// File: rtl/pair_checker.sv
module pair_checker
  import pair_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 stall,
  input logic                 s0Valid,
  input logic                 s1Valid,
  input logic [2:0]           s1Class,
  input logic [EXT_CNT_W-1:0] s1Ext,
  input logic                 priIssue,
  input logic                 secIssue,
  input logic                 secFwdA,
  input logic                 secFwdB,
  input logic [1:0]           consumed
);
  // R1
  sec_without_pri_chk: assert property (@(posedge clk) disable iff (!rstN)
    secIssue |-> priIssue);
  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    consumed != 2'd3);
  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stall) |-> (!priIssue && !secIssue));
  // R2
  pri_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!s0Valid) |-> !priIssue);
  // R2
  sec_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!s1Valid) |-> !secIssue);
  // R3
  solo_sec_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(s1Class == 3'd7) |-> !secIssue);
  // R4
  branch_sec_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(s1Class == 3'd6) |-> !secIssue);
  // R5
  ext_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(s1Ext > EXT_CNT_W'(SLOT_EXT_MAX)) |-> !secIssue);
  // R9
  fwd_only_paired_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secFwdA || secFwdB) |-> secIssue);
endmodule

bind dual_issue_pair pair_checker u_chk (.*);

// File: tb/sim_dual_issue_pair.sv
module sim_dual_issue_pair;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic       v;
    logic [2:0] c;
    logic [3:0] a;
    logic       ae;
    logic [3:0] b;
    logic       be;
    logic [3:0] d;
    logic       de;
    logic [1:0] sz;
    logic [4:0] ext;
  } dsc_t;

  typedef struct {
    logic  pri;
    logic  sec;
    logic  fa;
    logic  fb;
    string tag;
  } exp_t;

  dsc_t d0, d1;
  logic stall = 1'b0;
  logic priIssue, secIssue, secFwdA, secFwdB;
  logic [1:0] consumed;
  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  dual_issue_pair u0 (
    .clk(clk), .rstN(rstN), .stall(stall),
    .s0Valid(d0.v), .s0Class(d0.c), .s0SrcA(d0.a), .s0SrcAEn(d0.ae),
    .s0SrcB(d0.b), .s0SrcBEn(d0.be), .s0Dst(d0.d), .s0DstEn(d0.de),
    .s0Size(d0.sz), .s0Ext(d0.ext),
    .s1Valid(d1.v), .s1Class(d1.c), .s1SrcA(d1.a), .s1SrcAEn(d1.ae),
    .s1SrcB(d1.b), .s1SrcBEn(d1.be), .s1Dst(d1.d), .s1DstEn(d1.de),
    .s1Size(d1.sz), .s1Ext(d1.ext),
    .priIssue(priIssue), .secIssue(secIssue), .secFwdA(secFwdA),
    .secFwdB(secFwdB), .consumed(consumed)
  );

  function automatic dsc_t mk(input logic [2:0] c, input logic [3:0] a,
      input logic ae, input logic [3:0] b, input logic be,
      input logic [3:0] d, input logic de, input logic [1:0] sz,
      input logic [4:0] ext);
    mk = '{v:1'b1, c:c, a:a, ae:ae, b:b, be:be, d:d, de:de, sz:sz, ext:ext};
  endfunction

  // driver: present a pair, then queue what the next edge must produce
  task automatic drive(input dsc_t x0, input dsc_t x1, input logic st,
      input logic ePri, input logic eSec, input logic eFa, input logic eFb,
      input string tag);
    exp_t e;
    @(negedge clk);
    d0 = x0; d1 = x1; stall = st;
    @(posedge clk);
    #1;
    e.pri = ePri; e.sec = eSec; e.fa = eFa; e.fb = eFb; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare registered outputs at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [1:0] eCnt;
      e = q.pop_front();
      eCnt = {1'b0, e.pri} + {1'b0, e.sec};
      compared++;
      if (priIssue !== e.pri || secIssue !== e.sec || secFwdA !== e.fa ||
          secFwdB !== e.fb || consumed !== eCnt) begin
        mismatched++;
        $display("FAIL %s: got pri=%b sec=%b fa=%b fb=%b cnt=%0d exp pri=%b sec=%b fa=%b fb=%b cnt=%0d",
                 e.tag, priIssue, secIssue, secFwdA, secFwdB, consumed,
                 e.pri, e.sec, e.fa, e.fb, eCnt);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  localparam logic [2:0] ALU = 3'd0, MOVL = 3'd1, LEA = 3'd2, MOVI = 3'd3,
                         MOVQ = 3'd4, CLRL = 3'd5, BRNT = 3'd6, SOLO = 3'd7;
  localparam logic [1:0] BY = 2'd0, WD = 2'd1, LG = 2'd2;

  initial begin
    dsc_t aluD1, aluRd23, inv;
    aluD1   = mk(ALU, 4'd0, 1, 4'd1, 1, 4'd1, 1, LG, 5'd0);
    aluRd23 = mk(ALU, 4'd2, 1, 4'd3, 1, 4'd2, 1, LG, 5'd0);
    inv     = aluRd23; inv.v = 1'b0;
    d0 = aluD1; d1 = aluRd23;
    repeat (3) @(negedge clk);
    compared++;
    if (priIssue !== 1'b0 || secIssue !== 1'b0 || secFwdA !== 1'b0 ||
        secFwdB !== 1'b0 || consumed !== 2'd0) begin
      mismatched++;
      $display("FAIL R10 reset: got %b%b%b%b cnt=%0d exp 0000 cnt=0",
               priIssue, secIssue, secFwdA, secFwdB, consumed);
    end
    rstN = 1'b1;

    drive(aluD1, aluRd23, 0, 1, 1, 0, 0, "R1 independent pair");
    drive(aluD1, aluRd23, 1, 0, 0, 0, 0, "R2 stall");
    drive(inv,   aluRd23, 0, 0, 0, 0, 0, "R2 slot0 invalid");
    drive(aluD1, inv,     0, 1, 0, 0, 0, "R2 slot1 invalid");
    drive(mk(SOLO, 4'd0, 1, 4'd1, 0, 4'd9, 1, LG, 5'd0), aluRd23, 0, 1, 0, 0, 0, "R3 solo primary");
    drive(aluD1, mk(SOLO, 4'd2, 1, 4'd3, 0, 4'd2, 1, LG, 5'd0), 0, 1, 0, 0, 0, "R3 solo secondary");
    drive(mk(BRNT, 4'd0, 0, 4'd0, 0, 4'd0, 0, LG, 5'd2), aluRd23, 0, 1, 1, 0, 0, "R4 branch pairs");
    drive(aluD1, mk(BRNT, 4'd0, 0, 4'd0, 0, 4'd0, 0, LG, 5'd2), 0, 1, 0, 0, 0, "R4 branch secondary");
    drive(aluD1, mk(ALU, 4'd2, 1, 4'd3, 1, 4'd2, 1, LG, 5'd6), 0, 1, 1, 0, 0, "R5 ext 6 fits");
    drive(aluD1, mk(ALU, 4'd2, 1, 4'd3, 1, 4'd2, 1, LG, 5'd7), 0, 1, 0, 0, 0, "R5 ext 7 refused");
    drive(mk(ALU, 4'd0, 1, 4'd1, 1, 4'd1, 1, LG, 5'd12), aluRd23, 0, 1, 1, 0, 0, "R5 primary ext ok");
    drive(mk(ALU, 4'd0, 1, 4'd1, 1, 4'd4, 1, LG, 5'd0),
          mk(ALU, 4'd4, 1, 4'd3, 1, 4'd2, 1, LG, 5'd0), 0, 1, 0, 0, 0, "R6 dep srcA");
    drive(mk(ALU, 4'd0, 1, 4'd1, 1, 4'd4, 1, LG, 5'd0),
          mk(ALU, 4'd2, 1, 4'd4, 1, 4'd2, 1, LG, 5'd0), 0, 1, 0, 0, 0, "R6 dep srcB");
    drive(mk(MOVL, 4'd1, 1, 4'd0, 0, 4'd5, 1, LG, 5'd0),
          mk(ALU, 4'd5, 1, 4'd3, 1, 4'd2, 1, LG, 5'd0), 0, 1, 1, 1, 0, "R7 R9 move fwdA");
    drive(mk(LEA, 4'd8, 1, 4'd0, 0, 4'd10, 1, LG, 5'd2),
          mk(ALU, 4'd2, 1, 4'd10, 1, 4'd2, 1, LG, 5'd0), 0, 1, 1, 0, 1, "R7 R9 lea fwdB");
    drive(mk(MOVQ, 4'd0, 0, 4'd0, 0, 4'd0, 1, LG, 5'd0),
          mk(ALU, 4'd0, 1, 4'd0, 1, 4'd3, 1, LG, 5'd0), 0, 1, 1, 1, 1, "R7 R9 quick both");
    drive(mk(MOVI, 4'd0, 0, 4'd0, 0, 4'd11, 1, LG, 5'd4),
          mk(ALU, 4'd11, 1, 4'd3, 1, 4'd3, 1, LG, 5'd0), 0, 1, 1, 1, 0, "R7 long imm fwdA");
    drive(mk(CLRL, 4'd0, 0, 4'd0, 0, 4'd6, 1, LG, 5'd0),
          mk(ALU, 4'd2, 1, 4'd6, 1, 4'd2, 1, LG, 5'd0), 0, 1, 1, 0, 1, "R7 clear data reg");
    drive(mk(CLRL, 4'd0, 0, 4'd0, 0, 4'd9, 1, LG, 5'd0),
          mk(ALU, 4'd9, 1, 4'd3, 1, 4'd2, 1, LG, 5'd0), 0, 1, 0, 0, 0, "R7 clear addr reg");
    drive(mk(MOVL, 4'd1, 1, 4'd0, 0, 4'd5, 1, WD, 5'd0),
          mk(ALU, 4'd5, 1, 4'd3, 1, 4'd2, 1, LG, 5'd0), 0, 1, 0, 0, 0, "R8 word move");
    drive(mk(MOVL, 4'd1, 1, 4'd0, 0, 4'd5, 1, BY, 5'd0),
          mk(ALU, 4'd2, 1, 4'd5, 1, 4'd2, 1, LG, 5'd0), 0, 1, 0, 0, 0, "R8 byte move");
    drive(mk(ALU, 4'd0, 1, 4'd1, 1, 4'd7, 0, LG, 5'd0),
          mk(ALU, 4'd7, 1, 4'd3, 1, 4'd2, 1, LG, 5'd0), 0, 1, 1, 0, 0, "R6 R9 dst disabled");
    drive(mk(ALU, 4'd0, 1, 4'd1, 1, 4'd4, 1, LG, 5'd0),
          mk(ALU, 4'd4, 0, 4'd3, 1, 4'd2, 1, LG, 5'd0), 0, 1, 1, 0, 0, "R6 src disabled");
    drive(aluD1, aluRd23, 0, 1, 1, 0, 0, "R1 pair after refusals");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule